// File: doc/BRIEF.md
# HDLC Frame Transmitter with Zero Insertion

This block turns a stream of bytes into a framed serial bit stream on one line. Each frame goes out as an opening delimiter, the payload bytes, a 16-bit frame check sequence and a closing delimiter. Inside the frame body, which covers the payload and the check sequence, a zero is added after every run of five ones. Because of this, no run of six ones can appear anywhere except in a delimiter. When no frame is waiting, the line carries delimiters one after another without a gap.

The line advances one bit on each clock edge where `bit_en` is high, so the bit rate is set entirely by that strobe. Bytes arrive on a valid/ready interface, and `in_last` marks the final byte of a frame. The first byte taken after a frame has closed starts the next frame.

Back-pressure works as follows. `in_ready` is high only in a `bit_en` cycle in which the first bit of a new byte is due on the line. A byte is taken on that edge if `in_valid` is high. The source may hold `in_valid` high for as long as it likes. `in_ready` stays low on cycles that carry a delimiter bit or a stuffed zero, and on cycles that carry a bit from the middle of a byte or of the check sequence. If the source has no byte ready when a mid-frame byte is due, the frame is closed at that point.

Top module: `hdlc_tx`

## Requirements
- R1: While reset is held, `tx_line` is 1 and `in_ready` is 0. After reset the line sends at least one whole delimiter before a frame can begin, and it repeats delimiters for as long as no byte is offered.
- R2: The delimiter is the byte 0x7E, whose bit sequence is 0,1,1,1,1,1,1,0. No zero is ever inserted into it, so it carries six ones in a row on the line.
- R3: Within the frame body (payload bytes and check sequence), a 0 follows every run of five 1s on the line. Such runs are counted across byte boundaries and across the boundary between payload and check sequence. The stuffed 0 is emitted on the next `bit_en` cycle.
- R4: Payload bytes go out in the order they were accepted, each least significant bit first. The bit 0 of a byte taken on a clock edge is the line value right after that edge.
- R5: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1 in reflected form (0x8408), preset to 0xFFFF and computed over the payload bits only, without stuffed zeros. The ones complement of the result goes out least significant bit first. For the ASCII payload "123456789" the sequence is 0x906E, sent as byte 0x6E and then byte 0x90.
- R6: If a byte for the next frame is offered when the closing delimiter ends, exactly one delimiter lies between the two frames.
- R7: `in_ready` is high only in a cycle where `bit_en` is high. It is never high while a stuffed zero is due.
- R8: If `in_valid` is low when a mid-frame byte is due, the frame ends there. The block sends the check sequence over the bytes already sent, then the closing delimiter.
- R9: `tx_line` changes only on clock edges where `bit_en` is high.
- R10: A byte accepted with `in_last` high is followed directly by the check sequence and then the closing delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line pacing strobe; one line bit per high cycle |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | A payload byte is offered |
| in_last | input | 1 | The offered byte is the last of its frame |
| in_ready | output | 1 | The block takes the offered byte on this edge |
| tx_line | output | 1 | Serial line output |

## Verification
The main sweep sends each of the 256 byte values as a one-byte frame with the strobe high every cycle. This shows payload bit order, check-sequence arithmetic and zero insertion for every bit pattern. The frames follow one another, so the shared delimiter between frames is also exercised. A second sweep sends two-byte frames, several containing all-ones bytes, with the strobe at one cycle in three and then at an irregular rate. These frames separate correct counting of ones across byte boundaries from counting that restarts per byte, and they show that the line ignores idle strobe cycles. A withheld second byte tests the early close of a frame. The standard nine-digit payload pins the check-sequence value to a known constant rather than to a bench calculation.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;
  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    BK_FLAG = 2'd0,
    BK_DATA = 2'd1,
    BK_FCS  = 2'd2
  } bit_kind_e;

  localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
  localparam int          FLAG_LEN     = 8;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
endpackage

// File: rtl/hdlc_fcs.sv
module hdlc_fcs
  import hdlc_pkg::*;
#(
  parameter int          CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY   = CRC_POLY_REV,
  parameter logic [CRC_W-1:0] PRESET = CRC_PRESET
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  bit_kind_e kind,
  input  logic      line_bit,
  output logic      fcs_bit
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb      = crc_q[0] ^ line_bit;
  assign fcs_bit = ~crc_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (step) begin
      unique case (kind)
        BK_DATA: crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
        BK_FCS:  crc_q <= {1'b1, crc_q[CRC_W-1:1]};
        default: crc_q <= PRESET;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins
  import hdlc_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  bit_kind_e kind,
  input  logic      line_bit,
  output logic      stuff_pend
);
  localparam int ONES_W = $clog2(RUN_LEN + 1);

  logic [ONES_W-1:0] ones_q;
  logic              pend_q;

  assign stuff_pend = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
      pend_q <= 1'b0;
    end else if (bit_en) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        ones_q <= '0;
      end else if (kind == BK_FLAG || !line_bit) begin
        ones_q <= '0;
      end else if (ones_q == ONES_W'(RUN_LEN - 1)) begin
        pend_q <= 1'b1;
        ones_q <= '0;
      end else begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_fsm.sv
module hdlc_tx_fsm
  import hdlc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              stuff_pend,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              fcs_bit,
  output logic              in_ready,
  output logic              out_bit,
  output bit_kind_e         out_kind
);
  localparam int MAXV  = (CRC_W - 1 > BYTE_W) ? CRC_W - 1 : BYTE_W;
  localparam int CNT_W = $clog2(MAXV + 1) < 3 ? 3 : $clog2(MAXV + 1);

  tx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  idx_q, idx_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              last_q, last_n;
  logic              fdone_q, fdone_n;
  logic              need, take, step;

  assign step = bit_en & ~stuff_pend;

  always_comb begin
    unique case (state_q)
      ST_FLAG: need = fdone_q && (idx_q == '0);
      ST_DATA: need = (idx_q == CNT_W'(BYTE_W));
      default: need = 1'b0;
    endcase
    in_ready = step && need;
    take     = in_ready && in_valid;
  end

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    sh_n     = sh_q;
    last_n   = last_q;
    fdone_n  = fdone_q;
    out_bit  = 1'b1;
    out_kind = BK_FLAG;
    if (take) begin
      out_bit  = in_data[0];
      out_kind = BK_DATA;
      sh_n     = {1'b0, in_data[BYTE_W-1:1]};
      idx_n    = CNT_W'(1);
      last_n   = in_last;
      state_n  = ST_DATA;
    end else begin
      unique case (state_q)
        ST_FLAG: begin
          out_bit  = FLAG_PATTERN[idx_q[2:0]];
          out_kind = BK_FLAG;
          if (idx_q == CNT_W'(FLAG_LEN - 1)) begin
            idx_n   = '0;
            fdone_n = 1'b1;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (need) begin
            out_bit  = fcs_bit;
            out_kind = BK_FCS;
            state_n  = ST_FCS;
            idx_n    = CNT_W'(1);
          end else begin
            out_bit  = sh_q[0];
            out_kind = BK_DATA;
            sh_n     = sh_q >> 1;
            if (idx_q == CNT_W'(BYTE_W - 1)) begin
              if (last_q) begin
                state_n = ST_FCS;
                idx_n   = '0;
              end else begin
                idx_n = CNT_W'(BYTE_W);
              end
            end else begin
              idx_n = idx_q + 1'b1;
            end
          end
        end
        default: begin
          out_bit  = fcs_bit;
          out_kind = BK_FCS;
          if (idx_q == CNT_W'(CRC_W - 1)) begin
            state_n = ST_FLAG;
            idx_n   = '0;
            fdone_n = 1'b0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FLAG;
      idx_q   <= '0;
      sh_q    <= '0;
      last_q  <= 1'b0;
      fdone_q <= 1'b0;
    end else if (step) begin
      state_q <= state_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      last_q  <= last_n;
      fdone_q <= fdone_n;
    end
  end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CRC_W   = 16,
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_line
);
  logic      stuff_pend;
  logic      step;
  logic      out_bit;
  logic      fcs_bit;
  bit_kind_e out_kind;
  logic      line_q;

  assign step    = bit_en & ~stuff_pend;
  assign tx_line = line_q;

  hdlc_tx_fsm #(.BYTE_W(BYTE_W), .CRC_W(CRC_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .stuff_pend (stuff_pend),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .fcs_bit    (fcs_bit),
    .in_ready   (in_ready),
    .out_bit    (out_bit),
    .out_kind   (out_kind)
  );

  hdlc_fcs #(.CRC_W(CRC_W)) i_fcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .kind     (out_kind),
    .line_bit (out_bit),
    .fcs_bit  (fcs_bit)
  );

  hdlc_zero_ins #(.RUN_LEN(RUN_LEN)) i_zins (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .kind       (out_kind),
    .line_bit   (out_bit),
    .stuff_pend (stuff_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b1;
    end else if (bit_en) begin
      line_q <= stuff_pend ? 1'b0 : out_bit;
    end
  end
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_ready,
  input logic data_lsb,
  input logic tx_line,
  input logic stuff_pend
);
  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_line));

  // R7
  ready_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);

  // R7
  ready_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_pend |-> !in_ready);

  // R3
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_pend) |=> !tx_line);

  // R4
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_line == $past(data_lsb)));
endmodule

bind hdlc_tx hdlc_tx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .data_lsb   (in_data[0]),
  .tx_line    (tx_line),
  .stuff_pend (stuff_pend)
);

// File: tb/test_hdlc_tx.sv
module test_hdlc_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  wire        in_ready;
  wire        tx_line;

  always #2.5 clk = ~clk;

  hdlc_tx i_hdlc_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .tx_line  (tx_line)
  );

  int n_chk = 0, n_fail = 0;

  logic [7:0] s_data [0:1023];
  bit         s_last [0:1023];
  int         s_gap  [0:1023];
  int         s_n = 0;

  logic [7:0] e_data  [0:2047];
  int         e_start [0:599];
  int         e_len   [0:599];
  bit         e_b2b   [0:599];
  int         e_n = 0, e_bytes = 0;

  bit dbits [0:1023];
  int dn = 0, dones = 0, d_stuffed = 0, d_empty = 0, rx_n = 0, flags_seen = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic src_byte(logic [7:0] d, bit l, int g);
    s_data[s_n] = d; s_last[s_n] = l; s_gap[s_n] = g; s_n++;
  endtask

  task automatic exp_begin(bit b2b);
    e_start[e_n] = e_bytes; e_len[e_n] = 0; e_b2b[e_n] = b2b;
  endtask

  task automatic exp_byte(logic [7:0] d);
    e_data[e_bytes] = d; e_bytes++; e_len[e_n]++;
  endtask

  task automatic exp_end();
    e_n++;
  endtask

  // whole frame offered back to back, expected as one frame
  task automatic frame2(logic [7:0] a, logic [7:0] b, bit b2b);
    exp_begin(b2b); exp_byte(a); exp_byte(b); exp_end();
    src_byte(a, 1'b0, 0); src_byte(b, 1'b1, 0);
  endtask

  function automatic logic [15:0] fcs_of(int st, int len);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < len; k++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ e_data[st+k][j];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  function automatic int stuff_count(int st, int len, logic [15:0] f);
    int ones = 0, cnt = 0;
    for (int k = 0; k < len*8 + 16; k++) begin
      logic b = (k < len*8) ? e_data[st + k/8][k%8] : f[k - len*8];
      if (b) begin
        ones++;
        if (ones == 5) begin cnt++; ones = 0; end
      end else ones = 0;
    end
    return cnt;
  endfunction

  task automatic seg_end();
    int nb = dn - 7;
    flags_seen++;
    if (nb <= 0) d_empty++;
    else begin
      if (rx_n >= e_n) check(1'b0, "R4", "unexpected frame", rx_n, e_n);
      else begin
        int fi = rx_n, L = e_len[fi], st = e_start[fi];
        check(nb == (L + 2) * 8, "R4", "frame bit count", nb, (L + 2) * 8);
        if (nb == (L + 2) * 8) begin
          int mism = 0, mact = 0, mexp = 0;
          logic [15:0] frx, fexp;
          for (int k = 0; k < L + 2; k++) begin
            logic [7:0] by;
            for (int j = 0; j < 8; j++) by[j] = dbits[k*8 + j];
            if (k < L) begin
              if (by != e_data[st+k] && mism == 0) begin mact = by; mexp = e_data[st+k]; end
              if (by != e_data[st+k]) mism++;
            end else if (k == L) frx[7:0] = by;
            else frx[15:8] = by;
          end
          check(mism == 0, "R4", "payload byte", mact, mexp);
          fexp = fcs_of(st, L);
          check(frx == fexp, "R5", "check sequence", frx, fexp);
          if (fi == 0) check(frx == 16'h906E, "R5", "nine-digit constant", frx, 16'h906E);
          check(d_stuffed == stuff_count(st, L, fexp), "R3", "stuffed zero count",
                d_stuffed, stuff_count(st, L, fexp));
          if (e_b2b[fi]) check(d_empty == 0, "R6", "extra delimiters between frames", d_empty, 0);
        end
        rx_n++;
      end
      d_empty = 0;
    end
    dn = 0; d_stuffed = 0;
  endtask

  task automatic take_bit(logic b);
    if (b) begin
      dones++;
      if (dn < 1024) begin dbits[dn] = 1'b1; dn++; end
      if (dones == 7) check(1'b0, "R2", "seven ones on line", 7, 6);
    end else begin
      if (dones == 6) seg_end();
      else if (dones == 5) d_stuffed++;
      else if (dn < 1024) begin dbits[dn] = 1'b0; dn++; end
      dones = 0;
    end
  endtask

  initial begin
    int ptr = 0, wait_cnt = 0, cyc = 0, slow_start = 0, irr_start = 0;
    int r9_bad = 0, r7_bad = 0;
    logic prev_ben = 1'b0, prev_tx;
    logic [15:0] lfsr = 16'hACE1;
    string digits = "123456789";

    // R5 / R10: nine-digit frame; first byte waits so the line idles first
    exp_begin(1'b0);
    for (int k = 0; k < 9; k++) begin
      exp_byte(digits[k]);
      src_byte(digits[k], k == 8, k == 0 ? 200 : 0);
    end
    exp_end();
    // R8: second byte withheld, frame closes after the first
    exp_begin(1'b1); exp_byte(8'h11); exp_end();
    src_byte(8'h11, 1'b0, 0);
    exp_begin(1'b0); exp_byte(8'h22); exp_end();
    src_byte(8'h22, 1'b1, 40);
    // R4/R5/R6: every byte value as a one-byte frame
    for (int v = 0; v < 256; v++) begin
      exp_begin(v != 0); exp_byte(8'(v)); exp_end();
      src_byte(8'(v), 1'b1, v == 0 ? 60 : 0);
    end
    // R3/R9: two-byte frames under slower strobes
    slow_start = s_n;
    exp_begin(1'b1);
    for (int k = 0; k < 6; k++) exp_byte(k < 4 ? 8'hFF : 8'h7E);
    exp_end();
    for (int k = 0; k < 6; k++) src_byte(k < 4 ? 8'hFF : 8'h7E, k == 5, 0);
    for (int v = 0; v < 256; v++) begin
      if (v == 128) irr_start = s_n;
      frame2(8'(v), (v % 4 == 0) ? 8'hFF : (8'(v) ^ 8'h5A), 1'b1);
    end

    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check(tx_line == 1'b1, "R1", "line in reset", tx_line, 1);
    check(in_ready == 1'b0, "R1", "ready in reset", in_ready, 0);
    rst_n = 1'b1;
    wait_cnt = s_gap[0];
    prev_tx = tx_line;

    while (1) begin
      @(negedge clk);
      cyc++;
      if (prev_ben) take_bit(tx_line);
      else if (tx_line !== prev_tx) r9_bad++;
      prev_tx = tx_line;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ptr < slow_start) bit_en = 1'b1;
      else if (ptr < irr_start) bit_en = (cyc % 3 == 0);
      else bit_en = lfsr[0] | lfsr[5];
      if (ptr < s_n && wait_cnt == 0) begin
        in_valid = 1'b1; in_data = s_data[ptr]; in_last = s_last[ptr];
      end else begin
        in_valid = 1'b0;
        if (wait_cnt > 0) wait_cnt--;
      end
      #1;
      if (in_ready && !bit_en) r7_bad++;
      prev_ben = bit_en;
      if (in_valid && in_ready) begin
        ptr++;
        if (ptr < s_n) wait_cnt = s_gap[ptr];
      end
      if (cyc == 150) begin
        // R1: idle line carries only delimiters
        check(rx_n == 0, "R1", "frames while idle", rx_n, 0);
        check(flags_seen >= 15, "R1", "idle delimiters", flags_seen, 15);
      end
      if (rx_n == e_n && ptr == s_n) break;
      if (cyc >= 150000) begin
        check(1'b0, "R1", "watchdog expired", cyc, 150000);
        break;
      end
    end

    check(rx_n == e_n, "R10", "frames received", rx_n, e_n);
    check(r9_bad == 0, "R9", "line moved without strobe", r9_bad, 0);
    check(r7_bad == 0, "R7", "ready without strobe", r7_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule